// File: doc/BRIEF.md
# CAN Transmit Mailbox Controller

This block sits between software and a CAN bit-stream engine. It holds three transmit mailboxes. Each mailbox keeps a frame as four words: identifier, length, low data and high data. Software loads a mailbox through a word-wide register port and sets a request bit to queue it. The controller picks the next pending mailbox, hands its frame to the engine with a one-cycle start pulse, and records the outcome when the engine reports done. The engine is modelled as a start/done/ok handshake. A done with ok low stands for a failed or lost attempt.

There are two ordering policies. The first sends the pending mailbox with the lowest identifier first, and the lowest mailbox index wins a tie. The second sends mailboxes in the order they were requested. A second control input turns off automatic retransmission, so a failed attempt completes instead of being retried. Software can cancel a request through an abort bit. Completion and success flags are cleared by writing one to them. The state of all three mailboxes is packed into one status word.

Top module: `can_txmb_ctrl`

## Requirements
- R1: After reset all three mailboxes are empty, the status word reads 0x1C000000 and no start pulse is issued.
- R2: The register port uses word addresses. Address 0 is the status word. Mailbox k (0..2) sits at 4*(k+1) + w, where w = 0 is the identifier, 1 the length, 2 low data and 3 high data. Writing the identifier word of an empty mailbox with bit 0 = 1 queues it. The engine then receives the identifier word with bit 0 cleared, the 4-bit length from bits 3:0 of the length word, and both data words unchanged. The length word reads back with its upper 28 bits at zero.
- R3: Status layout: mailbox k has its completed flag at bit 8k, its OK flag at bit 8k+1, its abort-pending flag at bit 8k+7 and its empty flag at bit 26+k. All other bits read 0. The identifier word reads back its bit 0 as the request flag.
- R4: A done with ok = 1 sets completed = 1, OK = 1 and empty = 1 for the mailbox in flight, all at the same clock edge.
- R5: Writing 1 to a completed or OK bit clears that flag. Writing 0 leaves it unchanged.
- R6: Writing 1 to the abort bit of a mailbox that is pending but not yet started cancels it at that edge: completed = 1, OK = 0, empty = 1. The mailbox is never started.
- R7: An abort written while the mailbox is in flight sets its abort-pending bit. If the attempt then fails, the mailbox completes with OK = 0 and is not retried. If it succeeds, the mailbox completes with OK = 1.
- R8: With the order input low, the pending mailbox with the smallest identifier bits 31:3 starts first. On equal identifiers the lowest mailbox index starts first.
- R9: With the order input high, pending mailboxes start in the order in which their requests were written.
- R10: With the one-shot input low, a failed attempt leaves the mailbox pending (not empty, completed = 0), and it enters selection again.
- R11: With the one-shot input high, a failed attempt completes the mailbox with completed = 1, OK = 0 and empty = 1, and it is not started again.
- R12: Writes to any word of a mailbox that is not empty are ignored.
- R13: A new request clears the completed and OK flags of that mailbox.
- R14: At most one mailbox is in flight at a time, and each start is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cfg_fifo_order | input | 1 | 1: request order, 0: lowest identifier first |
| cfg_one_shot | input | 1 | 1: no automatic retransmission |
| eng_start | output | 1 | One-cycle pulse that starts an attempt |
| eng_slot | output | 2 | Mailbox index of the current attempt |
| eng_id | output | 32 | Identifier word of the frame, bit 0 cleared |
| eng_dlc | output | 4 | Data length code |
| eng_data_lo | output | 32 | Data bytes 0 to 3, byte 0 in bits 7:0 |
| eng_data_hi | output | 32 | Data bytes 4 to 7, byte 4 in bits 7:0 |
| eng_done | input | 1 | One-cycle pulse that ends the current attempt |
| eng_ok | input | 1 | Qualifies eng_done: 1 sent, 0 failed or lost |

## Verification
The assertions take for granted that the engine pulses eng_done for one cycle, only while an attempt is in flight, and at most once per start. They also assume that the two configuration inputs change only while no mailbox is pending, and that software never clears a flag by writing one in the same cycle as a done for that mailbox. The bench keeps within these limits in two ways. Its responder drives done only after it has seen a start, and it clears that record as it answers. It writes configuration and status-clear words only between completed attempts.

// File: rtl/can_txmb_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the transmit mailbox controller.
// Assumes exactly three mailboxes, because the packed status word has room for three.
package can_txmb_pkg;
    localparam int NUM_SLOTS      = 3;
    localparam int SLOT_IDX_W     = $clog2(NUM_SLOTS);
    localparam int WORD_W         = 32;
    localparam int DLC_W          = 4;
    localparam int ADDR_W         = 4;
    localparam int KEY_LSB        = 3;
    localparam int KEY_W          = WORD_W - KEY_LSB;
    localparam int ST_CMP_OFS     = 0;
    localparam int ST_OK_OFS      = 1;
    localparam int ST_ABRQ_OFS    = 7;
    localparam int ST_SLOT_STRIDE = 8;
    localparam int ST_EMPTY_BASE  = 26;

    typedef enum logic [1:0] {
        W_ID  = 2'd0,
        W_LEN = 2'd1,
        W_DLO = 2'd2,
        W_DHI = 2'd3
    } mb_word_e;

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [DLC_W-1:0]  dlc;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } frame_t;
endpackage

// File: rtl/txmb_slot.sv
`timescale 1ns/1ps
// One transmit mailbox: frame storage plus request, flight, completion,
// OK and abort-pending state.
// Assumes launch and done_ev arrive only from the launch unit, with done_ev only while in flight.
module txmb_slot
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  mb_word_e          wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_cmp,
    input  logic              clr_ok,
    input  logic              abort_req,
    input  logic              launch,
    input  logic              done_ev,
    input  logic              done_ok,
    input  logic              one_shot,
    output logic              pending,
    output logic              eligible,
    output logic              in_flight,
    output logic              cmp_flag,
    output logic              ok_flag,
    output logic              abrq_flag,
    output logic              req_event,
    output frame_t            frame
);
    logic accept_wr;
    logic cancel;

    assign accept_wr = wr_en && !pending;
    assign req_event = accept_wr && (wr_sel == W_ID) && wr_data[0];
    assign cancel    = abort_req && pending && !in_flight;
    assign eligible  = pending && !in_flight && !cancel;

    // Frame storage: writable only while the mailbox is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (accept_wr) begin
            case (wr_sel)
                W_ID:    frame.id  <= {wr_data[WORD_W-1:1], 1'b0};
                W_LEN:   frame.dlc <= wr_data[DLC_W-1:0];
                W_DLO:   frame.lo  <= wr_data;
                default: frame.hi  <= wr_data;
            endcase
        end
    end

    // Mailbox state: later statements take priority, so events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            in_flight <= 1'b0;
            cmp_flag  <= 1'b0;
            ok_flag   <= 1'b0;
            abrq_flag <= 1'b0;
        end else begin
            if (clr_cmp) cmp_flag <= 1'b0;
            if (clr_ok)  ok_flag  <= 1'b0;
            if (req_event) begin
                pending  <= 1'b1;
                cmp_flag <= 1'b0;
                ok_flag  <= 1'b0;
            end
            if (cancel) begin
                pending  <= 1'b0;
                cmp_flag <= 1'b1;
                ok_flag  <= 1'b0;
            end
            if (abort_req && in_flight) abrq_flag <= 1'b1;
            if (launch) in_flight <= 1'b1;
            if (done_ev) begin
                in_flight <= 1'b0;
                if (done_ok) begin
                    pending   <= 1'b0;
                    cmp_flag  <= 1'b1;
                    ok_flag   <= 1'b1;
                    abrq_flag <= 1'b0;
                end else if (one_shot || abrq_flag || abort_req) begin
                    pending   <= 1'b0;
                    cmp_flag  <= 1'b1;
                    ok_flag   <= 1'b0;
                    abrq_flag <= 1'b0;
                end
            end
        end
    end

    AST_CANCEL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (cmp_flag && !ok_flag && !pending)); // R6
    AST_SEND_OK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && done_ok) |=> (cmp_flag && ok_flag && !pending)); // R4
    AST_RETRY_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && !done_ok && !one_shot && !abrq_flag && !abort_req) |=> (pending && !in_flight && !cmp_flag)); // R10
    AST_ONESHOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && !done_ok && one_shot) |=> (cmp_flag && !ok_flag && !pending)); // R11
    AST_ABORT_FLIGHT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && !done_ok && abrq_flag) |=> (cmp_flag && !ok_flag && !pending)); // R7
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pending) |=> $stable(frame)); // R12
    AST_CMP_W0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cmp && !req_event && !cancel && !done_ev) |=> $stable(cmp_flag)); // R5
    AST_REQ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        req_event |=> (pending && !cmp_flag && !ok_flag)); // R13
endmodule

// File: rtl/txmb_order.sv
`timescale 1ns/1ps
// Chooses the next mailbox to send, by lowest key or by request age.
// Assumes at most one request event per cycle, and eligible already excludes mailboxes being cancelled.
module txmb_order #(
    parameter int N     = 3,
    parameter int KEY_W = 29
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fifo_mode,
    input  logic [N-1:0]              eligible,
    input  logic [N-1:0]              req_event,
    input  logic [N-1:0][KEY_W-1:0]   keys,
    output logic                      sel_valid,
    output logic [$clog2(N)-1:0]      sel_idx,
    output logic [N-1:0]              sel_onehot
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0][N-1:0] older_q;   // older_q[i][j]: i was requested before j
    logic [N-1:0]        win;

    // Age matrix: a new request becomes younger than every other mailbox.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    older_q[i][j] <= (i < j);
        end else begin
            for (int i = 0; i < N; i++) begin
                if (req_event[i]) begin
                    for (int j = 0; j < N; j++) begin
                        if (j != i) begin
                            older_q[i][j] <= 1'b0;
                            older_q[j][i] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Winner: eligible and beaten by no other eligible mailbox.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            win[i] = eligible[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && eligible[j]) begin
                    if (fifo_mode) begin
                        if (older_q[j][i]) win[i] = 1'b0;
                    end else if ((keys[j] < keys[i]) || ((keys[j] == keys[i]) && (j < i))) begin
                        win[i] = 1'b0;
                    end
                end
            end
        end
    end

    // Encode the winner index.
    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (win[i]) sel_idx = IDX_W'(i);
    end

    assign sel_onehot = win;
    assign sel_valid  = |win;

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win)); // R8
    AST_WINNER_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible) |-> sel_valid); // R9
endmodule

// File: rtl/txmb_launch.sv
`timescale 1ns/1ps
// Starts one attempt at a time on the engine, holds the frame on registered
// outputs, and routes done back to the mailbox that is in flight.
// Assumes eng_done pulses once per start, only while an attempt is in flight.
module txmb_launch
    import can_txmb_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_valid,
    input  logic [$clog2(N)-1:0]  sel_idx,
    input  logic [N-1:0]          sel_onehot,
    input  frame_t [N-1:0]        frames,
    input  logic                  eng_done,
    output logic [N-1:0]          launch_vec,
    output logic [N-1:0]          done_vec,
    output logic                  eng_start,
    output logic [$clog2(N)-1:0]  eng_slot,
    output frame_t                eng_frame
);
    logic   busy_q;
    logic   go;
    frame_t frame_mux;

    assign go         = sel_valid && !busy_q;
    assign launch_vec = go ? sel_onehot : '0;

    // Route done to the mailbox in flight.
    always_comb begin
        for (int i = 0; i < N; i++)
            done_vec[i] = eng_done && busy_q && (eng_slot == $clog2(N)'(i));
    end

    // Select the winning frame without an indexed read.
    always_comb begin
        frame_mux = '0;
        for (int i = 0; i < N; i++)
            if (sel_onehot[i]) frame_mux = frame_mux | frames[i];
    end

    // Engine handshake registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            eng_start <= 1'b0;
            eng_slot  <= '0;
            eng_frame <= '0;
        end else begin
            eng_start <= go;
            if (go) begin
                busy_q    <= 1'b1;
                eng_slot  <= sel_idx;
                eng_frame <= frame_mux;
            end else if (eng_done && busy_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy_q); // R14
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R14
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !eng_start); // R14
endmodule

// File: rtl/can_txmb_ctrl.sv
`timescale 1ns/1ps
// Transmit mailbox controller top: register decode, packed status word,
// three mailboxes, ordering and the engine handshake.
// Assumes one register access per cycle and configuration changes only while idle.
module can_txmb_ctrl
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cfg_fifo_order,
    input  logic              cfg_one_shot,
    output logic              eng_start,
    output logic [1:0]        eng_slot,
    output logic [31:0]       eng_id,
    output logic [3:0]        eng_dlc,
    output logic [31:0]       eng_data_lo,
    output logic [31:0]       eng_data_hi,
    input  logic              eng_done,
    input  logic              eng_ok
);
    localparam int MB_SEL_W = ADDR_W - 2;

    logic                           status_wr;
    mb_word_e                       wr_word;
    logic [NUM_SLOTS-1:0]           slot_wr;
    logic [NUM_SLOTS-1:0]           pend, elig, fly, cmp, okf, abrq, req_ev;
    logic [NUM_SLOTS-1:0]           launch_vec, done_vec, sel_onehot;
    logic [NUM_SLOTS-1:0][KEY_W-1:0] keys;
    frame_t [NUM_SLOTS-1:0]         frames;
    frame_t                         eng_frame;
    logic                           sel_valid;
    logic [SLOT_IDX_W-1:0]          sel_idx;
    logic [WORD_W-1:0]              status_word;

    assign status_wr = reg_wr && (reg_addr == '0);
    assign wr_word   = mb_word_e'(reg_addr[1:0]);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign slot_wr[k] = reg_wr && (reg_addr[ADDR_W-1:2] == MB_SEL_W'(k + 1));
        assign keys[k]    = frames[k].id[WORD_W-1:KEY_LSB];

        txmb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (slot_wr[k]),
            .wr_sel    (wr_word),
            .wr_data   (reg_wdata),
            .clr_cmp   (status_wr && reg_wdata[ST_SLOT_STRIDE*k + ST_CMP_OFS]),
            .clr_ok    (status_wr && reg_wdata[ST_SLOT_STRIDE*k + ST_OK_OFS]),
            .abort_req (status_wr && reg_wdata[ST_SLOT_STRIDE*k + ST_ABRQ_OFS]),
            .launch    (launch_vec[k]),
            .done_ev   (done_vec[k]),
            .done_ok   (eng_ok),
            .one_shot  (cfg_one_shot),
            .pending   (pend[k]),
            .eligible  (elig[k]),
            .in_flight (fly[k]),
            .cmp_flag  (cmp[k]),
            .ok_flag   (okf[k]),
            .abrq_flag (abrq[k]),
            .req_event (req_ev[k]),
            .frame     (frames[k])
        );
    end

    txmb_order #(.N(NUM_SLOTS), .KEY_W(KEY_W)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (cfg_fifo_order),
        .eligible   (elig),
        .req_event  (req_ev),
        .keys       (keys),
        .sel_valid  (sel_valid),
        .sel_idx    (sel_idx),
        .sel_onehot (sel_onehot)
    );

    txmb_launch #(.N(NUM_SLOTS)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_valid  (sel_valid),
        .sel_idx    (sel_idx),
        .sel_onehot (sel_onehot),
        .frames     (frames),
        .eng_done   (eng_done),
        .launch_vec (launch_vec),
        .done_vec   (done_vec),
        .eng_start  (eng_start),
        .eng_slot   (eng_slot),
        .eng_frame  (eng_frame)
    );

    assign eng_id      = eng_frame.id;
    assign eng_dlc     = eng_frame.dlc;
    assign eng_data_lo = eng_frame.lo;
    assign eng_data_hi = eng_frame.hi;

    // Pack per-mailbox flags into the status word.
    always_comb begin
        status_word = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            status_word[ST_SLOT_STRIDE*k + ST_CMP_OFS]  = cmp[k];
            status_word[ST_SLOT_STRIDE*k + ST_OK_OFS]   = okf[k];
            status_word[ST_SLOT_STRIDE*k + ST_ABRQ_OFS] = abrq[k];
            status_word[ST_EMPTY_BASE + k]              = !pend[k];
        end
    end

    // Read mux for the status word and the mailbox words.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[ADDR_W-1:2] == '0) begin
            if (reg_addr[1:0] == 2'd0) reg_rdata = status_word;
        end else begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (reg_addr[ADDR_W-1:2] == MB_SEL_W'(k + 1)) begin
                    case (wr_word)
                        W_ID:    reg_rdata = {frames[k].id[WORD_W-1:1], pend[k]};
                        W_LEN:   reg_rdata = {{(WORD_W-DLC_W){1'b0}}, frames[k].dlc};
                        W_DLO:   reg_rdata = frames[k].lo;
                        default: reg_rdata = frames[k].hi;
                    endcase
                end
            end
        end
    end

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fly)); // R14
    AST_EMPTY_AFTER_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_ok) |=> (status_word[ST_EMPTY_BASE + int'($past(eng_slot))] == 1'b1)); // R4
endmodule

// File: tb/test_can_txmb_ctrl.sv
`timescale 1ns/1ps
module test_can_txmb_ctrl;
    typedef struct packed {
        logic [1:0]  slot;
        logic [31:0] id;
        logic [3:0]  dlc;
        logic [31:0] lo;
        logic [31:0] hi;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_fifo_order = 1'b0;
    logic        cfg_one_shot = 1'b0;
    logic        eng_start;
    logic [1:0]  eng_slot;
    logic [31:0] eng_id, eng_data_lo, eng_data_hi;
    logic [3:0]  eng_dlc;
    logic        eng_done = 1'b0;
    logic        eng_ok = 1'b0;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   tb_fly = 1'b0;
    bit   prev_start = 1'b0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    can_txmb_ctrl i_can_txmb_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_fifo_order(cfg_fifo_order), .cfg_one_shot(cfg_one_shot),
        .eng_start(eng_start), .eng_slot(eng_slot), .eng_id(eng_id),
        .eng_dlc(eng_dlc), .eng_data_lo(eng_data_lo), .eng_data_hi(eng_data_hi),
        .eng_done(eng_done), .eng_ok(eng_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic expect_start(input int s, input logic [31:0] id, input logic [3:0] dlc,
                                input logic [31:0] lo, input logic [31:0] hi);
        exp_t e;
        e.slot = 2'(s); e.id = id & 32'hFFFF_FFFE; e.dlc = dlc; e.lo = lo; e.hi = hi;
        exp_q.push_back(e);
    endtask

    task automatic load(input int s, input logic [31:0] id, input logic [31:0] len,
                        input logic [31:0] lo, input logic [31:0] hi);
        wr(4'(4*(s+1)+1), len);
        wr(4'(4*(s+1)+2), lo);
        wr(4'(4*(s+1)+3), hi);
        wr(4'(4*(s+1)), id);
    endtask

    task automatic wait_fly();
        while (!tb_fly) @(negedge clk);
    endtask

    task automatic finish(input bit ok);
        wait_fly();
        @(negedge clk);
        eng_done = 1'b1; eng_ok = ok; tb_fly = 1'b0;
        @(negedge clk);
        eng_done = 1'b0; eng_ok = 1'b0;
    endtask

    // Scoreboard monitor: every start must match the oldest expected frame.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && eng_start) begin
            if (prev_start) check("R14 start pulse width", 32'd2, 32'd1);
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R6 R11: actual start of slot %0d expected no start", eng_slot);
            end else begin
                e = exp_q.pop_front();
                check("R8 R9 start slot", {30'd0, eng_slot}, {30'd0, e.slot});
                check("R2 engine id", eng_id, e.id);
                check("R2 engine dlc", {28'd0, eng_dlc}, {28'd0, e.dlc});
                check("R2 engine data lo", eng_data_lo, e.lo);
                check("R2 engine data hi", eng_data_hi, e.hi);
            end
            tb_fly = 1'b1;
        end
        prev_start = eng_start;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(4'd0, rv); check("R1 status after reset", rv, 32'h1C00_0000);
        check("R1 no start", {31'd0, eng_start}, 32'd0);

        // R2 R3 R4 R5 R12: basic send, status layout, write-one-to-clear
        expect_start(0, 32'h2460_0003, 4'd8, 32'h3322_1100, 32'h7766_5544);
        load(0, 32'h2460_0003, 32'hFFFF_FFF8, 32'h3322_1100, 32'h7766_5544);
        rd(4'd0, rv); check("R3 status slot0 pending", rv, 32'h1800_0000);
        rd(4'd5, rv); check("R2 length readback", rv, 32'h0000_0008);
        wr(4'd4, 32'h0000_0001);
        rd(4'd4, rv); check("R12 id write ignored while pending", rv, 32'h2460_0003);
        finish(1'b1);
        rd(4'd0, rv); check("R4 success flags", rv, 32'h1C00_0003);
        wr(4'd0, 32'h0000_0002);
        rd(4'd0, rv); check("R5 clear ok only", rv, 32'h1C00_0001);
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, rv); check("R5 zero write keeps flags", rv, 32'h1C00_0001);
        wr(4'd0, 32'h0000_0001);
        rd(4'd0, rv); check("R5 clear completed", rv, 32'h1C00_0000);

        // R8: lowest identifier first (extended frame flag in slot1)
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        load(0, 32'h0000_0011, 32'd1, 32'h0000_0A0A, 32'h0);
        wait_fly();
        expect_start(2, 32'h2000_0001, 4'd3, 32'h0000_0C0C, 32'h2);
        expect_start(1, 32'h8000_0005, 4'd2, 32'h0000_0B0B, 32'h1);
        load(1, 32'h8000_0005, 32'd2, 32'h0000_0B0B, 32'h1);
        load(2, 32'h2000_0001, 32'd3, 32'h0000_0C0C, 32'h2);
        finish(1'b1); finish(1'b1); finish(1'b1);
        rd(4'd0, rv); check("R4 all three complete", rv, 32'h1C03_0303);
        // R13: a new request clears old flags of that mailbox
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        wr(4'd4, 32'h0000_0011);
        rd(4'd0, rv); check("R13 new request clears flags", rv, 32'h1803_0300);
        finish(1'b1);
        wr(4'd0, 32'h0003_0303);
        rd(4'd0, rv); check("R5 clear all", rv, 32'h1C00_0000);

        // R9: request order
        cfg_fifo_order = 1'b1;
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        wr(4'd4, 32'h0000_0011);
        wait_fly();
        expect_start(1, 32'h8000_0005, 4'd2, 32'h0000_0B0B, 32'h1);
        expect_start(2, 32'h2000_0001, 4'd3, 32'h0000_0C0C, 32'h2);
        wr(4'd8, 32'h8000_0005);
        wr(4'd12, 32'h2000_0001);
        finish(1'b1); finish(1'b1); finish(1'b1);
        wr(4'd0, 32'h0003_0303);
        cfg_fifo_order = 1'b0;

        // R8: equal identifiers, lowest index first
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        wr(4'd4, 32'h0000_0011);
        wait_fly();
        expect_start(1, 32'h4000_0001, 4'd2, 32'h0000_0B0B, 32'h1);
        expect_start(2, 32'h4000_0001, 4'd3, 32'h0000_0C0C, 32'h2);
        wr(4'd12, 32'h4000_0001);
        wr(4'd8, 32'h4000_0001);
        finish(1'b1); finish(1'b1); finish(1'b1);
        wr(4'd0, 32'h0003_0303);
        rd(4'd0, rv); check("R8 idle after tie", rv, 32'h1C00_0000);

        // R10: retry on failure
        expect_start(1, 32'h4000_0001, 4'd2, 32'h0000_0B0B, 32'h1);
        expect_start(1, 32'h4000_0001, 4'd2, 32'h0000_0B0B, 32'h1);
        wr(4'd8, 32'h4000_0001);
        finish(1'b0);
        rd(4'd0, rv); check("R10 still pending after failure", rv, 32'h1400_0000);
        finish(1'b1);
        rd(4'd0, rv); check("R10 retry succeeded", rv, 32'h1C00_0300);
        wr(4'd0, 32'h0003_0303);

        // R11: one-shot failure completes without retry
        cfg_one_shot = 1'b1;
        expect_start(2, 32'h4000_0001, 4'd3, 32'h0000_0C0C, 32'h2);
        wr(4'd12, 32'h4000_0001);
        finish(1'b0);
        rd(4'd0, rv); check("R11 one-shot failure", rv, 32'h1C01_0000);
        wr(4'd0, 32'h0003_0303);
        cfg_one_shot = 1'b0;

        // R6 R12: abort a pending mailbox that has not started
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        wr(4'd4, 32'h0000_0011);
        wait_fly();
        wr(4'd8, 32'h4000_0001);
        rd(4'd0, rv); check("R3 two pending", rv, 32'h1000_0000);
        wr(4'd5, 32'h0000_000F);
        rd(4'd5, rv); check("R12 length write ignored while pending", rv, 32'h0000_0001);
        wr(4'd0, 32'h0000_8000);
        rd(4'd0, rv); check("R6 abort cancels pending", rv, 32'h1800_0100);
        finish(1'b1);
        rd(4'd0, rv); check("R6 aborted never sent", rv, 32'h1C00_0103);
        wr(4'd0, 32'h0003_0303);

        // R7: abort during flight, attempt fails, then succeeds
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        wr(4'd4, 32'h0000_0011);
        wait_fly();
        wr(4'd0, 32'h0000_0080);
        rd(4'd0, rv); check("R7 abort pending bit", rv, 32'h1800_0080);
        finish(1'b0);
        rd(4'd0, rv); check("R7 aborted failure completes", rv, 32'h1C00_0001);
        wr(4'd0, 32'h0003_0303);
        expect_start(0, 32'h0000_0011, 4'd1, 32'h0000_0A0A, 32'h0);
        wr(4'd4, 32'h0000_0011);
        wait_fly();
        wr(4'd0, 32'h0000_0080);
        finish(1'b1);
        rd(4'd0, rv); check("R7 aborted success completes ok", rv, 32'h1C00_0003);

        repeat (10) @(negedge clk);
        check("R11 no outstanding starts", exp_q.size(), 32'd0);
        report();
    end
endmodule